// File: doc/BRIEF.md
# Branch Condition Evaluator with Loop and Set Logic

This block turns a 4-bit condition selector and the four arithmetic flags (negative, zero, overflow, carry) into a single true/false verdict. Three kinds of instruction use that verdict. A conditional branch takes the branch when the verdict is true. A set-on-condition operation writes a byte that is all ones when the verdict is true and all zeros when it is false. A decrement-and-loop operation reads the verdict as "stop looping".

The branch verdict and the set byte are purely combinational. The loop helper is a one-cycle registered stage. It accepts a request strobe and a counter register, and one cycle later it returns the updated counter together with a flag that says whether to branch back.

When the verdict is true, the loop falls through and leaves the counter untouched. When it is false, the loop decrements the low counter field. It branches back unless that field has wrapped to all ones. Computing the branch target and the program counter belongs to neighbouring logic.

Top module: `cond_unit`

## Requirements
- R1: Selector 0 always yields true and selector 1 always yields false, whatever the flags. In the loop, selector 1 is the plain "always decrement" form.
- R2: Selector 2 (unsigned higher) is true when carry and zero are both clear. Selector 3 (unsigned lower-or-same) is true when carry or zero is set.
- R3: Selector 4 is true when carry is clear and selector 5 when carry is set. Selector 6 is true when zero is clear and selector 7 when zero is set.
- R4: Selector 8 is true when overflow is clear and selector 9 when overflow is set. Selector 10 is true when negative is clear and selector 11 when negative is set.
- R5: Selector 12 (signed greater-or-equal) is true when negative equals overflow. Selector 13 (signed less) is true when they differ. Selector 14 (signed greater) is true when zero is clear and negative equals overflow. Selector 15 (signed less-or-equal) is true when zero is set or negative differs from overflow.
- R6: `set_byte` is all ones while `cond_true` is 1 and all zeros while it is 0, in the same cycle.
- R7: For a loop request whose verdict is true, the returned counter equals the input counter and `loop_branch` is 0.
- R8: For a loop request whose verdict is false, the low 16 bits of the returned counter are the input's low 16 bits minus one, and the upper 16 bits are unchanged. `loop_branch` is 1 unless the new low field is 0xFFFF.
- R9: A false-verdict loop request with a low field of 0x0000 returns a low field of 0xFFFF with `loop_branch` 0, and the upper bits are kept.
- R10: `loop_done` is high for exactly one cycle, the cycle after each cycle in which `loop_req` was high, and low otherwise. After reset, `loop_done`, `loop_cnt_out` and `loop_branch` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_sel | input | 4 | Condition selector, 0 to 15 |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| cond_true | output | 1 | Combinational verdict; branch-taken for a conditional branch |
| set_byte | output | 8 | All-ones or all-zeros result for set-on-condition |
| loop_req | input | 1 | Loop step request, sampled at the clock edge |
| loop_cnt_in | input | 32 | Counter register value for the loop step |
| loop_done | output | 1 | Loop result valid, one cycle after the request |
| loop_cnt_out | output | 32 | Updated counter register value |
| loop_branch | output | 1 | 1 = branch back, 0 = fall through |

## Verification
The bench builds the block with its default parameters: a 32-bit counter register, a 16-bit decremented field and an 8-bit set result. These sizes let it check all 256 combinations of selector and flags for both the verdict and the set byte. The 16-bit field also puts the boundary values 0x0000, 0x0001 and 0xFFFF within reach, along with upper bits that must survive the wrap. The loop requests are issued back to back and also with gaps between them, so the one-cycle result strobe is checked in both cases.

// File: rtl/cond_unit_pkg.sv
package cond_unit_pkg;

    typedef enum logic [3:0] {
        CND_TRUE  = 4'd0,
        CND_FALSE = 4'd1,
        CND_HIGH  = 4'd2,
        CND_LOSM  = 4'd3,
        CND_CCLR  = 4'd4,
        CND_CSET  = 4'd5,
        CND_NEQ   = 4'd6,
        CND_EQL   = 4'd7,
        CND_VCLR  = 4'd8,
        CND_VSET  = 4'd9,
        CND_POS   = 4'd10,
        CND_NEG   = 4'd11,
        CND_SGE   = 4'd12,
        CND_SLT   = 4'd13,
        CND_SGT   = 4'd14,
        CND_SLE   = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    // Selector pairs share one base test; bit 0 of the selector inverts it.
    typedef enum logic [2:0] {
        BASE_ALWAYS = 3'd0,
        BASE_UHI    = 3'd1,
        BASE_NOCARRY= 3'd2,
        BASE_NONZERO= 3'd3,
        BASE_NOOVF  = 3'd4,
        BASE_NONNEG = 3'd5,
        BASE_SGE    = 3'd6,
        BASE_SGT    = 3'd7
    } base_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_unit_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     flags,
    output logic       verdict
);

    base_e base;
    logic  base_true;
    logic  sign_ok;

    always_comb begin
        base    = base_e'(sel[3:1]);
        sign_ok = (flags.n == flags.v);
        case (base)
            BASE_ALWAYS:  base_true = 1'b1;
            BASE_UHI:     base_true = !flags.c && !flags.z;
            BASE_NOCARRY: base_true = !flags.c;
            BASE_NONZERO: base_true = !flags.z;
            BASE_NOOVF:   base_true = !flags.v;
            BASE_NONNEG:  base_true = !flags.n;
            BASE_SGE:     base_true = sign_ok;
            BASE_SGT:     base_true = sign_ok && !flags.z;
            default:      base_true = 1'b0;
        endcase
        verdict = base_true ^ sel[0];
    end

endmodule

// File: rtl/set_fill.sv
module set_fill #(
    parameter int SET_W = 8
) (
    input  logic             bit_in,
    output logic [SET_W-1:0] fill_out
);

    genvar i;
    generate
        for (i = 0; i < SET_W; i++) begin : g_lane
            assign fill_out[i] = bit_in;
        end
    endgenerate

endmodule

// File: rtl/loop_step.sv
module loop_step #(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             stop,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             done,
    output logic [CNT_W-1:0] cnt_out,
    output logic             branch
);

    localparam logic [LOOP_W-1:0] LOW_WRAP = '1;
    localparam logic [LOOP_W-1:0] LOW_ONE  = LOOP_W'(1);

    typedef struct packed {
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic             branch;
    } step_t;

    step_t st_d, st_q;
    logic [LOOP_W-1:0] low_dec;

    always_comb begin
        st_d      = st_q;
        st_d.done = req;
        low_dec   = cnt_in[LOOP_W-1:0] - LOW_ONE;
        if (req) begin
            st_d.cnt = cnt_in;
            if (stop) begin
                st_d.branch = 1'b0;
            end else begin
                st_d.cnt[LOOP_W-1:0] = low_dec;
                st_d.branch          = (low_dec != LOW_WRAP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign cnt_out = st_q.cnt;
    assign branch  = st_q.branch;

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done) else $error("done missing"); // R10
    AST_DONE_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done) else $error("stray done"); // R10
    AST_STOP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && stop) |=> (cnt_out == $past(cnt_in) && !branch)) else $error("count touched"); // R7
    AST_UPPER_PRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (cnt_out[CNT_W-1:LOOP_W] == $past(cnt_in[CNT_W-1:LOOP_W]))) else $error("upper bits"); // R8
    AST_WRAP_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cnt_out[LOOP_W-1:0] == LOW_WRAP) |-> !branch) else $error("wrap branched"); // R9

endmodule

// File: rtl/cond_unit.sv
module cond_unit
    import cond_unit_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOOP_W = 16,
    parameter int SET_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cond_sel,
    input  logic             flag_n,
    input  logic             flag_z,
    input  logic             flag_v,
    input  logic             flag_c,
    output logic             cond_true,
    output logic [SET_W-1:0] set_byte,
    input  logic             loop_req,
    input  logic [CNT_W-1:0] loop_cnt_in,
    output logic             loop_done,
    output logic [CNT_W-1:0] loop_cnt_out,
    output logic             loop_branch
);

    flags_t flags;
    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    cond_eval u_eval (
        .sel     (cond_sel),
        .flags   (flags),
        .verdict (cond_true)
    );

    set_fill #(.SET_W(SET_W)) u_fill (
        .bit_in   (cond_true),
        .fill_out (set_byte)
    );

    loop_step #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (loop_req),
        .stop    (cond_true),
        .cnt_in  (loop_cnt_in),
        .done    (loop_done),
        .cnt_out (loop_cnt_out),
        .branch  (loop_branch)
    );

    AST_NEVER_FALSE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd1) |-> !cond_true) else $error("sel 1 true"); // R1
    AST_ALWAYS_TRUE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 4'd0) |-> cond_true) else $error("sel 0 false"); // R1
    AST_SET_TRACKS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_byte == '0 && !cond_true) || (set_byte == '1 && cond_true)) else $error("set byte"); // R6

endmodule

// File: tb/sim_cond_unit.sv
`timescale 1ns/1ps
module sim_cond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
    logic        cond_true;
    logic [7:0]  set_byte;
    logic        loop_req = 1'b0;
    logic [31:0] loop_cnt_in = '0;
    logic        loop_done;
    logic [31:0] loop_cnt_out;
    logic        loop_branch;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] cnt;
        logic        br;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    cond_unit u0 (
        .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .cond_true(cond_true), .set_byte(set_byte),
        .loop_req(loop_req), .loop_cnt_in(loop_cnt_in),
        .loop_done(loop_done), .loop_cnt_out(loop_cnt_out), .loop_branch(loop_branch)
    );

    function automatic logic ref_cond(int code, logic n, logic z, logic v, logic c);
        case (code)
            0: return 1'b1;
            1: return 1'b0;
            2: return !c && !z;
            3: return c || z;
            4: return !c;
            5: return c;
            6: return !z;
            7: return z;
            8: return !v;
            9: return v;
            10: return !n;
            11: return n;
            12: return n == v;
            13: return n != v;
            14: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    function automatic string tag_of(int code);
        if (code < 2) return "R1";
        if (code < 4) return "R2";
        if (code < 8) return "R3";
        if (code < 12) return "R4";
        return "R5";
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one loop request per cycle, expected result pushed to scoreboard.
    task automatic loop_op(logic [31:0] cnt, int code, logic [3:0] f, string tag);
        logic stop;
        exp_t e;
        @(negedge clk);
        cond_sel = code[3:0];
        {flag_n, flag_z, flag_v, flag_c} = f;
        loop_cnt_in = cnt;
        loop_req = 1'b1;
        stop = ref_cond(code, f[3], f[2], f[1], f[0]);
        e.tag = tag;
        if (stop) begin
            e.cnt = cnt;
            e.br  = 1'b0;
        end else begin
            e.cnt = {cnt[31:16], cnt[15:0] - 16'd1};
            e.br  = (e.cnt[15:0] != 16'hFFFF);
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        loop_req = 1'b0;
    endtask

    // Monitor: compares each result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (loop_done) begin
                if (sb.size() == 0) begin
                    check(0, "R10", "unexpected loop_done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(loop_cnt_out == e.cnt, e.tag, "loop_cnt_out", loop_cnt_out, e.cnt);
                    check(loop_branch == e.br, e.tag, "loop_branch", {31'd0, loop_branch}, {31'd0, e.br});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state, R10
        check(loop_done == 1'b0, "R10", "reset loop_done", {31'd0, loop_done}, 32'd0);
        check(loop_cnt_out == 32'd0, "R10", "reset loop_cnt_out", loop_cnt_out, 32'd0);
        check(loop_branch == 1'b0, "R10", "reset loop_branch", {31'd0, loop_branch}, 32'd0);

        // Exhaustive verdict and set byte: R1..R5, R6
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                logic exp_v;
                @(negedge clk);
                cond_sel = code[3:0];
                {flag_n, flag_z, flag_v, flag_c} = f[3:0];
                #1;
                exp_v = ref_cond(code, flag_n, flag_z, flag_v, flag_c);
                check(cond_true == exp_v, tag_of(code), $sformatf("cond_true sel=%0d flags=%0h", code, f),
                      {31'd0, cond_true}, {31'd0, exp_v});
                check(set_byte == {8{exp_v}}, "R6", $sformatf("set_byte sel=%0d flags=%0h", code, f),
                      {24'd0, set_byte}, {24'd0, {8{exp_v}}});
            end
        end

        // Loop steps, back to back
        loop_op(32'h1234_0005, 0, 4'h0, "R7");
        loop_op(32'hABCD_0005, 1, 4'hF, "R8");
        loop_op(32'h5555_0000, 1, 4'h0, "R9");
        loop_op(32'h0F0F_0001, 1, 4'h0, "R8");
        loop_op(32'h8000_FFFF, 1, 4'h0, "R8");
        loop_op(32'h0000_0010, 7, 4'h4, "R7");
        loop_op(32'h0000_0010, 7, 4'h0, "R8");
        idle();
        // Gap: no result may appear two cycles after the last request
        @(negedge clk);
        check(loop_done == 1'b0, "R10", "loop_done in gap", {31'd0, loop_done}, 32'd0);
        loop_op(32'hFFFF_0000, 14, 4'h0, "R7");
        idle();
        loop_op(32'h7777_0000, 13, 4'h0, "R9");
        loop_op(32'h0001_FFFF, 12, 4'h8, "R8");
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10", "pending loop results", sb.size(), 32'd0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule